// File: doc/BRIEF.md
# Loader Command Message Assembler

This block sits between a serial frame layer and a command executor in a boot loader. The frame layer passes in 7-byte payloads. Each payload comes with a one-cycle valid strobe, a block kind and a count of meaningful bytes. The assembler decides whether each payload opens a command, extends one, or closes one. It stores the command bytes in arrival order and gives the executor a one-cycle ready pulse together with the total byte count. The executor reads the stored bytes through a random-access read port.

When the executor finishes, it returns a done pulse. The pulse carries a status code, a flag marking a command that starts code execution, and a read-back length. The executor can place read-back bytes in the same buffer through a byte write port. The assembler then produces the reply. A read-back reply is split into full data blocks, followed by one final end block. Any other reply is a single status block. A code-start command with a clean status gets no reply. After the reply, the assembler goes back to waiting for a new command header.

Top module: `ldr_msg_assembler`

## Requirements
- R1: In the idle state, a header block (kind 0) whose type byte (payload byte 0, bits 7:0) has bit 7 set is a complete command. In the cycle after it is accepted, `cmd_ready` pulses with `cmd_single`=1 and `cmd_count` equal to the header byte count.
- R2: A header block whose type bit 7 is clear starts a collection and raises no ready pulse. Each data block (kind 1) appends its counted bytes after those already stored. Kind 3 is reserved.
- R3: An end block (kind 2) during collection appends its bytes and then pulses `cmd_ready` with `cmd_single`=0 and the total count. Byte n of the command, counted in arrival order from 0, is read at `rd_addr`=n.
- R4: A block that would raise the collected total above 137 bytes aborts the collection. No ready pulse follows, the stored count drops to 0, and the assembler returns to header polling. A total of exactly 137 is accepted.
- R5: A block that does not fit the current state restarts the assembler at header polling with no ready pulse. These are data, end or reserved blocks while idle, and header or reserved blocks during collection. A header that arrives during collection is not taken as a new command.
- R6: A read-back reply sends data blocks (kind 1, 7 bytes) while more than 7 bytes remain. It then sends exactly one end block (kind 2) that carries the remaining 1 to 7 bytes, zero-padded. Buffer byte 0 is in payload lane 0 (bits 7:0).
- R7: If the status byte is non-zero, or if there is no read-back and no code start, the reply is one status block (kind 3, count 1, status byte in lane 0). A clean code-start command with no read-back gets no reply. After the reply, the next header is accepted.
- R8: Payload lanes at or above the block's byte count are not stored. Reads at or above the current command count return 0.
- R9: A header that arrives while a command is executing or replying is dropped and raises no ready pulse. Bit 7 of the next status byte is then set, and the bit clears once it has been reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_valid | input | 1 | Payload strobe, one cycle per block |
| blk_kind | input | 2 | 0 header, 1 data, 2 end, 3 reserved |
| blk_cnt | input | 3 | Meaningful bytes in the payload (0 to 7) |
| blk_data | input | 56 | Payload, lane 0 in bits 7:0 |
| cmd_ready | output | 1 | Complete command pulse |
| cmd_single | output | 1 | Command came from a single header |
| cmd_count | output | 8 | Stored command byte count |
| rd_addr | input | 8 | Executor read address |
| rd_data | output | 8 | Stored byte, 0 at or past the count |
| wr_en | input | 1 | Executor read-back byte write |
| wr_addr | input | 8 | Read-back write address |
| wr_byte | input | 8 | Read-back write data |
| exec_done | input | 1 | Executor finished, one-cycle pulse |
| exec_status | input | 7 | Executor status code |
| exec_run | input | 1 | Command starts code execution |
| rb_len | input | 8 | Read-back byte count |
| rsp_valid | output | 1 | Reply block available |
| rsp_ready | input | 1 | Frame layer takes the reply block |
| rsp_kind | output | 2 | 1 data, 2 end, 3 status |
| rsp_cnt | output | 3 | Meaningful bytes in the reply block |
| rsp_data | output | 56 | Reply payload, lane 0 in bits 7:0 |

## Verification
The bench fills a command to exactly 137 bytes, then sends one that reaches 138. A design with an off-by-one cap would either drop the legal maximum or accept the oversize command. It splits read-back lengths of 17, 7 and 8 bytes. A faulty splitter would send a data block for data that fits in the end block, or would lose the last byte. An end block with garbage in its unused lanes shows whether those lanes leak into storage or into reads. A header sent mid-collection, and another sent while the executor is busy, check that neither is taken as a fresh command. They also check that the busy case is reported once in the status byte and then cleared.

// File: rtl/ldr_msg_pkg.sv
package ldr_msg_pkg;

   typedef enum logic [1:0] {
      BK_HDR  = 2'd0,
      BK_DATA = 2'd1,
      BK_END  = 2'd2,
      BK_RSV  = 2'd3
   } blk_kind_e;

   typedef enum logic [1:0] {
      RK_NONE = 2'd0,
      RK_DATA = 2'd1,
      RK_END  = 2'd2,
      RK_STAT = 2'd3
   } rsp_kind_e;

   typedef enum logic [1:0] {
      S_IDLE,
      S_COLLECT,
      S_EXEC,
      S_RESP
   } asm_state_e;

   typedef enum logic [2:0] {
      EV_NONE,
      EV_SINGLE,
      EV_MULTI,
      EV_APPEND,
      EV_FINAL,
      EV_ABORT,
      EV_BUSY
   } asm_event_e;

endpackage

// File: rtl/ldr_msg_classify.sv
module ldr_msg_classify
   import ldr_msg_pkg::*;
#(
   parameter int BLK_BYTES = 7,
   parameter int MAX_BYTES = 137,
   localparam int LANE_W = $clog2(BLK_BYTES + 1),
   localparam int CNT_W  = $clog2(MAX_BYTES + 1),
   localparam int SUM_W  = CNT_W + 1
) (
   input  logic              valid,
   input  logic [1:0]        kind,
   input  logic [LANE_W-1:0] cnt,
   input  logic              type_msb,
   input  asm_state_e        state,
   input  logic [CNT_W-1:0]  count,
   output asm_event_e        ev,
   output logic [SUM_W-1:0]  sum
);

   logic lane_ok;
   logic fits;

   assign sum     = {1'b0, count} + SUM_W'(cnt);
   assign fits    = (sum <= SUM_W'(MAX_BYTES));
   assign lane_ok = (cnt <= LANE_W'(BLK_BYTES));

   always_comb begin
      ev = EV_NONE;
      if (valid) begin
         case (state)
            S_IDLE: begin
               if (kind == BK_HDR && cnt != '0 && lane_ok)
                  ev = type_msb ? EV_SINGLE : EV_MULTI;
               else
                  ev = EV_ABORT;
            end
            S_COLLECT: begin
               if (!lane_ok)
                  ev = EV_ABORT;
               else if (kind == BK_DATA)
                  ev = fits ? EV_APPEND : EV_ABORT;
               else if (kind == BK_END)
                  ev = fits ? EV_FINAL : EV_ABORT;
               else
                  ev = EV_ABORT;
            end
            default: ev = (kind == BK_HDR) ? EV_BUSY : EV_NONE;
         endcase
      end
   end

endmodule

// File: rtl/ldr_msg_buffer.sv
module ldr_msg_buffer #(
   parameter int BLK_BYTES = 7,
   parameter int MAX_BYTES = 137,
   localparam int LANE_W = $clog2(BLK_BYTES + 1),
   localparam int CNT_W  = $clog2(MAX_BYTES + 1),
   localparam int ADDR_W = $clog2(MAX_BYTES),
   localparam int IW     = CNT_W + 1,
   localparam int BW     = 8 * BLK_BYTES
) (
   input  logic              clk,
   input  logic              app_en,
   input  logic [CNT_W-1:0]  app_base,
   input  logic [LANE_W-1:0] app_cnt,
   input  logic [BW-1:0]     app_data,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_byte,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_byte,
   input  logic [CNT_W-1:0]  win_base,
   output logic [BW-1:0]     win_data
);

   logic [7:0]        mem [MAX_BYTES];
   logic [IW-1:0]     lane_idx [BLK_BYTES];
   logic [BLK_BYTES-1:0] lane_on;

   for (genvar j = 0; j < BLK_BYTES; j++) begin : g_lane
      logic [IW-1:0] widx;
      assign lane_idx[j] = {1'b0, app_base} + IW'(j);
      assign lane_on[j]  = app_en && (LANE_W'(j) < app_cnt) &&
                           (lane_idx[j] < IW'(MAX_BYTES));
      assign widx = {1'b0, win_base} + IW'(j);
      assign win_data[8*j +: 8] = (widx < IW'(MAX_BYTES)) ?
                                  mem[widx[ADDR_W-1:0]] : 8'h00;
   end

   always_ff @(posedge clk) begin
      for (int j = 0; j < BLK_BYTES; j++) begin
         if (lane_on[j])
            mem[lane_idx[j][ADDR_W-1:0]] <= app_data[8*j +: 8];
      end
      if (wr_en && (CNT_W'(wr_addr) < CNT_W'(MAX_BYTES)))
         mem[wr_addr] <= wr_byte;
   end

   assign rd_byte = (CNT_W'(rd_addr) < CNT_W'(MAX_BYTES)) ? mem[rd_addr] : 8'h00;

endmodule

// File: rtl/ldr_msg_resp.sv
module ldr_msg_resp
   import ldr_msg_pkg::*;
#(
   parameter int BLK_BYTES = 7,
   parameter int MAX_BYTES = 137,
   localparam int LANE_W = $clog2(BLK_BYTES + 1),
   localparam int CNT_W  = $clog2(MAX_BYTES + 1),
   localparam int BW     = 8 * BLK_BYTES
) (
   input  logic              active,
   input  logic              stat_mode,
   input  logic [7:0]        stat_byte,
   input  logic [CNT_W-1:0]  rem,
   input  logic [BW-1:0]     win_data,
   output logic [1:0]        kind,
   output logic [LANE_W-1:0] cnt,
   output logic [BW-1:0]     data,
   output logic              last
);

   logic [BW-1:0] tail;

   for (genvar j = 0; j < BLK_BYTES; j++) begin : g_pad
      assign tail[8*j +: 8] = (CNT_W'(j) < rem) ? win_data[8*j +: 8] : 8'h00;
   end

   always_comb begin
      kind = RK_NONE;
      cnt  = '0;
      data = '0;
      last = 1'b0;
      if (active) begin
         if (stat_mode) begin
            kind = RK_STAT;
            cnt  = LANE_W'(1);
            data = BW'(stat_byte);
            last = 1'b1;
         end else if (rem > CNT_W'(BLK_BYTES)) begin
            kind = RK_DATA;
            cnt  = LANE_W'(BLK_BYTES);
            data = win_data;
         end else begin
            kind = RK_END;
            cnt  = LANE_W'(rem);
            data = tail;
            last = 1'b1;
         end
      end
   end

endmodule

// File: rtl/ldr_msg_assembler.sv
module ldr_msg_assembler
   import ldr_msg_pkg::*;
#(
   parameter int BLK_BYTES = 7,
   parameter int MAX_BYTES = 137,
   parameter int STAT_W    = 7,
   localparam int LANE_W = $clog2(BLK_BYTES + 1),
   localparam int CNT_W  = $clog2(MAX_BYTES + 1),
   localparam int ADDR_W = $clog2(MAX_BYTES),
   localparam int SUM_W  = CNT_W + 1,
   localparam int BW     = 8 * BLK_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blk_valid,
   input  logic [1:0]        blk_kind,
   input  logic [LANE_W-1:0] blk_cnt,
   input  logic [BW-1:0]     blk_data,
   output logic              cmd_ready,
   output logic              cmd_single,
   output logic [CNT_W-1:0]  cmd_count,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_byte,
   input  logic              exec_done,
   input  logic [STAT_W-1:0] exec_status,
   input  logic              exec_run,
   input  logic [CNT_W-1:0]  rb_len,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [1:0]        rsp_kind,
   output logic [LANE_W-1:0] rsp_cnt,
   output logic [BW-1:0]     rsp_data
);

   if (BLK_BYTES < 1) begin : g_bad_blk
      $error("BLK_BYTES must be at least 1");
   end
   if (MAX_BYTES < BLK_BYTES) begin : g_bad_max
      $error("MAX_BYTES must hold at least one block");
   end
   if (STAT_W < 1 || STAT_W > 7) begin : g_bad_stat
      $error("STAT_W must leave bit 7 free for the busy flag");
   end

   asm_state_e        st;
   asm_event_e        ev;
   logic [SUM_W-1:0]  sum;
   logic [CNT_W-1:0]  count, ptr, rem;
   logic              rdy_q, single_q, busy_q, stat_mode_q;
   logic [7:0]        stat_q, done_stat, rd_byte;
   logic [BW-1:0]     win_data;
   logic              app_en, rsp_last;
   logic [CNT_W-1:0]  rb_clamped;

   ldr_msg_classify #(.BLK_BYTES(BLK_BYTES), .MAX_BYTES(MAX_BYTES)) u_classify (
      .valid(blk_valid), .kind(blk_kind), .cnt(blk_cnt), .type_msb(blk_data[7]),
      .state(st), .count(count), .ev(ev), .sum(sum)
   );

   assign app_en = (ev == EV_SINGLE) || (ev == EV_MULTI) ||
                   (ev == EV_APPEND) || (ev == EV_FINAL);

   ldr_msg_buffer #(.BLK_BYTES(BLK_BYTES), .MAX_BYTES(MAX_BYTES)) u_buffer (
      .clk(clk), .app_en(app_en),
      .app_base((st == S_IDLE) ? '0 : count),
      .app_cnt(blk_cnt), .app_data(blk_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_byte(wr_byte),
      .rd_addr(rd_addr), .rd_byte(rd_byte),
      .win_base(ptr), .win_data(win_data)
   );

   ldr_msg_resp #(.BLK_BYTES(BLK_BYTES), .MAX_BYTES(MAX_BYTES)) u_resp (
      .active(st == S_RESP), .stat_mode(stat_mode_q), .stat_byte(stat_q),
      .rem(rem), .win_data(win_data),
      .kind(rsp_kind), .cnt(rsp_cnt), .data(rsp_data), .last(rsp_last)
   );

   assign done_stat  = {busy_q | (ev == EV_BUSY), 7'(exec_status)};
   assign rb_clamped = (rb_len > CNT_W'(MAX_BYTES)) ? CNT_W'(MAX_BYTES) : rb_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= S_IDLE;
         count       <= '0;
         ptr         <= '0;
         rem         <= '0;
         rdy_q       <= 1'b0;
         single_q    <= 1'b0;
         busy_q      <= 1'b0;
         stat_mode_q <= 1'b0;
         stat_q      <= '0;
      end else begin
         rdy_q <= 1'b0;
         case (st)
            S_IDLE, S_COLLECT: begin
               case (ev)
                  EV_SINGLE: begin
                     count <= CNT_W'(blk_cnt); single_q <= 1'b1;
                     rdy_q <= 1'b1;            st <= S_EXEC;
                  end
                  EV_MULTI: begin
                     count <= CNT_W'(blk_cnt); single_q <= 1'b0;
                     st <= S_COLLECT;
                  end
                  EV_APPEND: count <= CNT_W'(sum);
                  EV_FINAL: begin
                     count <= CNT_W'(sum); rdy_q <= 1'b1; st <= S_EXEC;
                  end
                  EV_ABORT: begin
                     count <= '0; st <= S_IDLE;
                  end
                  default: ;
               endcase
            end
            S_EXEC: begin
               if (exec_done) begin
                  busy_q <= 1'b0;
                  ptr    <= '0;
                  rem    <= rb_clamped;
                  stat_q <= done_stat;
                  if (done_stat != 8'h00) begin
                     stat_mode_q <= 1'b1; st <= S_RESP;
                  end else if (rb_clamped != '0) begin
                     stat_mode_q <= 1'b0; st <= S_RESP;
                  end else if (exec_run) begin
                     st <= S_IDLE;
                  end else begin
                     stat_mode_q <= 1'b1; st <= S_RESP;
                  end
               end else if (ev == EV_BUSY) begin
                  busy_q <= 1'b1;
               end
            end
            default: begin
               if (ev == EV_BUSY) busy_q <= 1'b1;
               if (rsp_ready) begin
                  if (rsp_last) begin
                     st <= S_IDLE;
                  end else begin
                     ptr <= ptr + CNT_W'(BLK_BYTES);
                     rem <= rem - CNT_W'(BLK_BYTES);
                  end
               end
            end
         endcase
      end
   end

   assign cmd_ready  = rdy_q;
   assign cmd_single = single_q;
   assign cmd_count  = count;
   assign rsp_valid  = (st == S_RESP);
   assign rd_data    = (CNT_W'(rd_addr) < count) ? rd_byte : 8'h00;

   // R1
   ready_in_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> (st == S_EXEC && cmd_count != '0));
   // R4
   count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_count <= CNT_W'(MAX_BYTES));
   // R5
   idle_misfit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE && blk_valid && blk_kind != BK_HDR) |=> (st == S_IDLE && !cmd_ready));
   // R6
   data_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_ready && rsp_kind == RK_DATA) |=> rsp_valid);
   // R7
   reply_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_ready && rsp_kind != RK_DATA) |=> (st == S_IDLE));
   // R9
   busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == S_EXEC || st == S_RESP) && blk_valid) |=> !cmd_ready);

endmodule

// File: tb/ldr_msg_assembler_bench.sv
`timescale 1ns/1ps
module ldr_msg_assembler_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        blk_valid = 1'b0;
   logic [1:0]  blk_kind = '0;
   logic [2:0]  blk_cnt = '0;
   logic [55:0] blk_data = '0;
   logic        cmd_ready, cmd_single;
   logic [7:0]  cmd_count;
   logic [7:0]  rd_addr = '0;
   logic [7:0]  rd_data;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0, wr_byte = '0;
   logic        exec_done = 1'b0;
   logic [6:0]  exec_status = '0;
   logic        exec_run = 1'b0;
   logic [7:0]  rb_len = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b1;
   logic [1:0]  rsp_kind;
   logic [2:0]  rsp_cnt;
   logic [55:0] rsp_data;

   int checks = 0;
   int errors = 0;
   logic        got_rdy, got_single;
   logic [7:0]  got_cnt;
   int          nrsp;
   logic [1:0]  rk [16];
   logic [2:0]  rc [16];
   logic [55:0] rd [16];

   always #5 clk = ~clk;

   ldr_msg_assembler u_ldr_msg_assembler (
      .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_kind(blk_kind),
      .blk_cnt(blk_cnt), .blk_data(blk_data), .cmd_ready(cmd_ready),
      .cmd_single(cmd_single), .cmd_count(cmd_count), .rd_addr(rd_addr),
      .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_byte(wr_byte),
      .exec_done(exec_done), .exec_status(exec_status), .exec_run(exec_run),
      .rb_len(rb_len), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_kind(rsp_kind), .rsp_cnt(rsp_cnt), .rsp_data(rsp_data)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [55:0] pay(input logic [7:0] seed);
      logic [55:0] p;
      for (int j = 0; j < 7; j++) p[8*j +: 8] = seed + 8'(j);
      return p;
   endfunction

   task automatic send(input logic [1:0] k, input logic [2:0] c, input logic [55:0] d);
      @(negedge clk);
      blk_valid = 1'b1; blk_kind = k; blk_cnt = c; blk_data = d;
      @(negedge clk);
      got_rdy = cmd_ready; got_single = cmd_single; got_cnt = cmd_count;
      blk_valid = 1'b0;
   endtask

   task automatic peek(input logic [7:0] a, output logic [7:0] v);
      rd_addr = a;
      #1 v = rd_data;
   endtask

   task automatic fill_rb(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         wr_en = 1'b1; wr_addr = 8'(i); wr_byte = 8'hA0 + 8'(i);
      end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic finish_cmd(input logic [6:0] s, input logic run, input logic [7:0] len);
      @(negedge clk);
      exec_done = 1'b1; exec_status = s; exec_run = run; rb_len = len;
      @(negedge clk);
      exec_done = 1'b0;
      nrsp = 0;
      while (rsp_valid && nrsp < 16) begin
         rk[nrsp] = rsp_kind; rc[nrsp] = rsp_cnt; rd[nrsp] = rsp_data;
         nrsp++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      logic [7:0] v;
      chk("R1 reset ready", 64'(cmd_ready), 64'd0);
      chk("R7 reset rsp_valid", 64'(rsp_valid), 64'd0);
      peek(8'd0, v);
      chk("R8 reset read", 64'(v), 64'd0);
   endtask

   task automatic t_single();
      logic [7:0] v;
      send(2'd0, 3'd7, {pay(8'h40)} | 56'h85);
      chk("R1 ready", 64'(got_rdy), 64'd1);
      chk("R1 single", 64'(got_single), 64'd1);
      chk("R1 count", 64'(got_cnt), 64'd7);
      peek(8'd3, v);
      chk("R1 byte3", 64'(v), 64'h43);
      finish_cmd(7'd0, 1'b0, 8'd0);
      chk("R7 one status block", 64'(nrsp), 64'd1);
      chk("R7 status kind", 64'(rk[0]), 64'd3);
      chk("R7 status cnt", 64'(rc[0]), 64'd1);
      chk("R7 status data", 64'(rd[0]), 64'd0);
   endtask

   task automatic t_multi();
      logic [7:0] v;
      send(2'd0, 3'd7, (pay(8'h10) & ~56'hFF) | 56'h05);
      chk("R2 no ready on multi header", 64'(got_rdy), 64'd0);
      send(2'd1, 3'd7, pay(8'h20));
      chk("R2 no ready on data", 64'(got_rdy), 64'd0);
      send(2'd2, 3'd3, 56'hEEEEEEEE_323130);
      chk("R3 ready", 64'(got_rdy), 64'd1);
      chk("R3 single clear", 64'(got_single), 64'd0);
      chk("R3 total", 64'(got_cnt), 64'd17);
      peek(8'd0, v);  chk("R3 byte0", 64'(v), 64'h05);
      peek(8'd9, v);  chk("R2 byte9", 64'(v), 64'h22);
      peek(8'd16, v); chk("R3 last byte", 64'(v), 64'h32);
      peek(8'd17, v); chk("R8 past count", 64'(v), 64'h00);
      finish_cmd(7'd0, 1'b1, 8'd0);
      chk("R7 code start silent", 64'(nrsp), 64'd0);
      send(2'd0, 3'd2, 56'h0181);
      chk("R7 idle after code start", 64'(got_rdy), 64'd1);
      finish_cmd(7'd0, 1'b0, 8'd0);
   endtask

   task automatic t_boundary();
      logic [7:0] v;
      logic [55:0] e;
      send(2'd0, 3'd7, pay(8'h01));
      for (int i = 0; i < 18; i++) send(2'd1, 3'd7, pay(8'h50));
      send(2'd2, 3'd4, 56'h00000063626160);
      chk("R4 exactly 137 ready", 64'(got_rdy), 64'd1);
      chk("R4 exactly 137 count", 64'(got_cnt), 64'd137);
      peek(8'd136, v);
      chk("R4 byte136", 64'(v), 64'h63);
      fill_rb(17);
      finish_cmd(7'd0, 1'b0, 8'd17);
      chk("R6 block count 17", 64'(nrsp), 64'd3);
      chk("R6 kind0", 64'(rk[0]), 64'd1);
      chk("R6 kind1", 64'(rk[1]), 64'd1);
      chk("R6 kind2", 64'(rk[2]), 64'd2);
      chk("R6 cnt2", 64'(rc[2]), 64'd3);
      chk("R6 data0", 64'(rd[0]), 64'(pay(8'hA0)));
      chk("R6 data1", 64'(rd[1]), 64'(pay(8'hA7)));
      e = 56'h0000000_0B0AFAE;
      chk("R6 end data padded", 64'(rd[2]), 64'(e));
      send(2'd0, 3'd1, 56'h80);
      fill_rb(7);
      finish_cmd(7'd0, 1'b0, 8'd7);
      chk("R6 seven bytes one end", 64'(nrsp), 64'd1);
      chk("R6 seven kind", 64'(rk[0]), 64'd2);
      chk("R6 seven cnt", 64'(rc[0]), 64'd7);
      send(2'd0, 3'd1, 56'h80);
      fill_rb(8);
      finish_cmd(7'd0, 1'b0, 8'd8);
      chk("R6 eight blocks", 64'(nrsp), 64'd2);
      chk("R6 eight kind0", 64'(rk[0]), 64'd1);
      chk("R6 eight end cnt", 64'(rc[1]), 64'd1);
      chk("R6 eight end data", 64'(rd[1]), 64'hA7);
   endtask

   task automatic t_overflow();
      logic [7:0] v;
      send(2'd0, 3'd7, pay(8'h02));
      for (int i = 0; i < 18; i++) send(2'd1, 3'd7, pay(8'h50));
      send(2'd2, 3'd5, pay(8'h70));
      chk("R4 138 no ready", 64'(got_rdy), 64'd0);
      peek(8'd0, v);
      chk("R4 count dropped", 64'(v), 64'd0);
      send(2'd1, 3'd7, pay(8'h11));
      chk("R5 data in idle", 64'(got_rdy), 64'd0);
      send(2'd0, 3'd1, 56'h84);
      chk("R4 header after abort", 64'(got_rdy), 64'd1);
      finish_cmd(7'd0, 1'b0, 8'd0);
   endtask

   task automatic t_misfit();
      send(2'd2, 3'd3, pay(8'h01));
      chk("R5 end in idle", 64'(got_rdy), 64'd0);
      send(2'd0, 3'd7, pay(8'h06));
      send(2'd0, 3'd7, 56'h81);
      chk("R5 header mid collect not taken", 64'(got_rdy), 64'd0);
      send(2'd2, 3'd2, pay(8'h01));
      chk("R5 end after restart", 64'(got_rdy), 64'd0);
      send(2'd0, 3'd7, pay(8'h06));
      send(2'd3, 3'd1, pay(8'h01));
      send(2'd2, 3'd1, pay(8'h01));
      chk("R5 reserved aborts", 64'(got_rdy), 64'd0);
   endtask

   task automatic t_busy();
      send(2'd0, 3'd1, 56'h82);
      chk("R9 first ready", 64'(got_rdy), 64'd1);
      send(2'd0, 3'd1, 56'h83);
      chk("R9 busy header dropped", 64'(got_rdy), 64'd0);
      finish_cmd(7'd0, 1'b0, 8'd0);
      chk("R9 busy status", 64'(rd[0]), 64'h80);
      send(2'd0, 3'd1, 56'h82);
      finish_cmd(7'd0, 1'b0, 8'd0);
      chk("R9 flag cleared", 64'(rd[0]), 64'h00);
      send(2'd0, 3'd1, 56'h82);
      finish_cmd(7'h15, 1'b0, 8'd5);
      chk("R7 failure single block", 64'(nrsp), 64'd1);
      chk("R7 failure kind", 64'(rk[0]), 64'd3);
      chk("R7 failure code", 64'(rd[0]), 64'h15);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1 t_reset();
      rst_n = 1'b1;
      t_single();
      t_multi();
      t_boundary();
      t_overflow();
      t_misfit();
      t_busy();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule